// File: doc/BRIEF.md
# Packet Transmit and Receive Byte Buffer Controller

This block sits between a host register port and the byte-serial datapath of a packet radio. It holds two 16-entry byte FIFOs, one feeding the transmitter and one filled by the receiver. The packet length is counted separately from the storage, so a packet of up to 40 bytes can pass through a 16-byte FIFO. For that to work the host must refill the transmit FIFO while bytes leave it, and must drain the receive FIFO while bytes arrive.

To send, the host writes payload bytes into the transmit FIFO, writes a length, and issues a start command. From then on the serializer side pulls one byte per request until the length count is used up. A packet of 16 bytes or fewer needs no further host action. To receive, the deserializer side announces a packet start with its length and then offers bytes. Bytes marked as acknowledge traffic are ignored, so neither buffer is touched by them. Status outputs report transmit free space, receive fill level, an "at least half" threshold on each side, packet completion, and sticky underrun and overflow errors.

Top module: `pkt_buf_ctrl`

## Requirements
- R1: After reset, the transmit FIFO reports 16 free bytes, the receive FIFO holds 0 bytes, tx_space is 1, and tx_active, tx_underrun, rx_avail, rx_complete and rx_overflow are all 0.
- R2: A host write with host_addr = 0 appends host_wdata to the transmit FIFO, in order. Such a write while the FIFO holds 16 bytes and no byte leaves in the same cycle is dropped, and tx_free stays 0.
- R3: A host write with host_addr = 1 sets the packet length, saturating at 40. A host write with host_addr = 2 starts a packet with that length: tx_active rises, each tx_req answered by tx_valid delivers the oldest byte, and tx_active falls once exactly that many bytes have been delivered.
- R4: tx_space is 1 exactly when tx_free is 8 or more.
- R5: A tx_req while tx_active is 1 and the transmit FIFO is empty delivers no byte, consumes no length, and sets tx_underrun. tx_underrun stays set until the next start command clears it.
- R6: When a FIFO is full, a write and a read that arrive in the same cycle both take effect, and the fill level stays at 16. On the transmit side these are a host write and a consumer pop. On the receive side they are an arriving byte and a host read.
- R7: rx_start empties the receive FIFO, clears rx_complete and rx_overflow, and loads the receive length (saturating at 40). Bytes are stored only while some of that length remains; later bytes are ignored.
- R8: rx_avail is 1 when the receive FIFO holds 8 or more bytes, or when rx_complete is 1 and the FIFO is not empty.
- R9: A byte that arrives while the receive FIFO is full and no host read occurs in the same cycle is dropped and sets rx_overflow, which is sticky. The dropped byte still counts against the packet length.
- R10: A byte offered with rx_ack = 1 changes neither the receive FIFO nor the remaining receive length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select: 0 tx byte, 1 length, 2 start, 3 none |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host pop of the receive FIFO head |
| host_rdata | output | 8 | Receive FIFO head byte |
| tx_req | input | 1 | Serializer requests a byte |
| tx_valid | output | 1 | A byte is delivered this cycle |
| tx_data | output | 8 | Delivered byte |
| tx_active | output | 1 | Transmit length not yet used up |
| tx_underrun | output | 1 | Sticky transmit underrun |
| tx_space | output | 1 | At least 8 bytes free in the transmit FIFO |
| tx_free | output | 5 | Free entries in the transmit FIFO |
| rx_start | input | 1 | Receive packet begins |
| rx_len | input | 8 | Receive packet length, sampled with rx_start |
| rx_valid | input | 1 | Receive byte strobe |
| rx_ack | input | 1 | Current byte belongs to acknowledge traffic |
| rx_byte | input | 8 | Received byte |
| rx_count | output | 5 | Bytes held in the receive FIFO |
| rx_avail | output | 1 | Receive data available |
| rx_complete | output | 1 | Whole receive length has arrived |
| rx_overflow | output | 1 | Sticky receive overflow |

## Verification
The transmit FIFO can be written by the host in the same cycle that the serializer pops it. The receive FIFO can accept a byte in the same cycle that the host reads it. The collision that matters is when the FIFO is already full. The bench fills each FIFO to 16 entries and then drives both sides together: 24 consecutive cycles of write-plus-pop on the transmit side, and one byte-plus-read on the receive side. It then requires the level to stay at 16 and no overflow to be raised. The scoreboard queues confirm that no byte was lost or reordered across the collision, including for the full 40-byte packet.

// File: rtl/pkt_buf_pkg.sv
package pkt_buf_pkg;

    localparam int BUF_DEPTH   = 16;
    localparam int BYTE_W      = 8;
    localparam int PKT_MAX_LEN = 40;
    localparam int HALF_MARK   = 8;

    typedef enum logic [1:0] {
        SEL_TX_BYTE = 2'd0,
        SEL_TX_LEN  = 2'd1,
        SEL_TX_GO   = 2'd2,
        SEL_NONE    = 2'd3
    } host_sel_e;

    typedef struct packed {
        logic active;
        logic underrun;
    } tx_stat_t;

    typedef struct packed {
        logic complete;
        logic overflow;
        logic avail;
    } rx_stat_t;

    function automatic logic [7:0] clamp_len(input logic [7:0] v, input logic [7:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic [CW-1:0] count
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic          is_full, is_empty, push_acc, pop_acc;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign pop_acc  = pop && !is_empty && !flush;
    assign push_acc = push && !flush && (!is_full || pop_acc);
    assign rdata    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_acc) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) wr_ptr <= step(wr_ptr);
            if (pop_acc)  rd_ptr <= step(rd_ptr);
            case ({push_acc, pop_acc})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (is_full && push && !pop && !flush) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/pkt_tx_ctrl.sv
module pkt_tx_ctrl
    import pkt_buf_pkg::*;
#(
    parameter int MAX_LEN = 40,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       len_wr,
    input  logic [7:0] len_in,
    input  logic       go,
    input  logic       req,
    input  logic       fifo_empty,
    output logic       pop,
    output tx_stat_t   stat
);
    logic [LEN_W-1:0] len_q, remain_q;
    logic             underrun_q;
    logic             active;

    assign active        = (remain_q != '0);
    assign pop           = req && active && !fifo_empty;
    assign stat.active   = active;
    assign stat.underrun = underrun_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q      <= '0;
            remain_q   <= '0;
            underrun_q <= 1'b0;
        end else begin
            if (len_wr) len_q <= LEN_W'(clamp_len(len_in, 8'(MAX_LEN)));
            if (go) begin
                remain_q   <= len_q;
                underrun_q <= 1'b0;
            end else begin
                if (pop) remain_q <= remain_q - LEN_W'(1);
                if (req && active && fifo_empty) underrun_q <= 1'b1;
            end
        end
    end

    // R3
    len_cap_chk: assert property (@(posedge clk) disable iff (rst)
        len_q <= LEN_W'(MAX_LEN));

    // R5
    underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun_q) |-> $past(req && fifo_empty));

    // R5
    underrun_clear_chk: assert property (@(posedge clk) disable iff (rst)
        go |=> !underrun_q);

    // R3
    remain_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!go && pop) |=> (remain_q == $past(remain_q) - LEN_W'(1)));

endmodule

// File: rtl/pkt_rx_ctrl.sv
module pkt_rx_ctrl
    import pkt_buf_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int MAX_LEN = 40,
    parameter int THRESH  = 8,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [7:0]    len_in,
    input  logic          valid,
    input  logic          ack,
    input  logic          host_rd,
    input  logic [CW-1:0] fifo_count,
    output logic          push,
    output rx_stat_t      stat
);
    logic [LEN_W-1:0] remain_q;
    logic             complete_q, overflow_q;
    logic             take, fifo_full;

    assign fifo_full     = (fifo_count == CW'(DEPTH));
    assign take          = valid && !ack && !start && (remain_q != '0);
    assign push          = take;
    assign stat.complete = complete_q;
    assign stat.overflow = overflow_q;
    assign stat.avail    = (fifo_count >= CW'(THRESH)) || (complete_q && fifo_count != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q   <= '0;
            complete_q <= 1'b0;
            overflow_q <= 1'b0;
        end else if (start) begin
            remain_q   <= LEN_W'(clamp_len(len_in, 8'(MAX_LEN)));
            complete_q <= 1'b0;
            overflow_q <= 1'b0;
        end else if (take) begin
            remain_q <= remain_q - LEN_W'(1);
            if (remain_q == LEN_W'(1)) complete_q <= 1'b1;
            if (fifo_full && !host_rd) overflow_q <= 1'b1;
        end
    end

    // R10
    ack_no_effect_chk: assert property (@(posedge clk) disable iff (rst)
        (valid && ack && !start) |=> $stable(remain_q));

    // R9
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow_q) |-> $past(fifo_full && !host_rd));

    // R7
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (!overflow_q && !complete_q));

endmodule

// File: rtl/pkt_buf_ctrl.sv
module pkt_buf_ctrl
    import pkt_buf_pkg::*;
#(
    parameter int DEPTH   = BUF_DEPTH,
    parameter int MAX_LEN = PKT_MAX_LEN,
    parameter int THRESH  = HALF_MARK,
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [1:0]    host_addr,
    input  logic [7:0]    host_wdata,
    input  logic          host_rd,
    output logic [7:0]    host_rdata,
    input  logic          tx_req,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_active,
    output logic          tx_underrun,
    output logic          tx_space,
    output logic [CW-1:0] tx_free,
    input  logic          rx_start,
    input  logic [7:0]    rx_len,
    input  logic          rx_valid,
    input  logic          rx_ack,
    input  logic [7:0]    rx_byte,
    output logic [CW-1:0] rx_count,
    output logic          rx_avail,
    output logic          rx_complete,
    output logic          rx_overflow
);
    host_sel_e     sel;
    logic          tx_push, tx_len_wr, tx_go, tx_pop, rx_push;
    logic [CW-1:0] tx_count;
    tx_stat_t      tx_stat;
    rx_stat_t      rx_stat;

    assign sel       = host_sel_e'(host_addr);
    assign tx_push   = host_wr && (sel == SEL_TX_BYTE);
    assign tx_len_wr = host_wr && (sel == SEL_TX_LEN);
    assign tx_go     = host_wr && (sel == SEL_TX_GO);

    pkt_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(1'b0),
        .push(tx_push), .pop(tx_pop), .wdata(host_wdata),
        .rdata(tx_data), .count(tx_count)
    );

    pkt_tx_ctrl #(.MAX_LEN(MAX_LEN)) u_tx_ctrl (
        .clk(clk), .rst(rst), .len_wr(tx_len_wr), .len_in(host_wdata),
        .go(tx_go), .req(tx_req), .fifo_empty(tx_count == '0),
        .pop(tx_pop), .stat(tx_stat)
    );

    pkt_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(rx_start),
        .push(rx_push), .pop(host_rd), .wdata(rx_byte),
        .rdata(host_rdata), .count(rx_count)
    );

    pkt_rx_ctrl #(.DEPTH(DEPTH), .MAX_LEN(MAX_LEN), .THRESH(THRESH)) u_rx_ctrl (
        .clk(clk), .rst(rst), .start(rx_start), .len_in(rx_len),
        .valid(rx_valid), .ack(rx_ack), .host_rd(host_rd),
        .fifo_count(rx_count), .push(rx_push), .stat(rx_stat)
    );

    assign tx_valid    = tx_pop;
    assign tx_active   = tx_stat.active;
    assign tx_underrun = tx_stat.underrun;
    assign tx_free     = CW'(DEPTH) - tx_count;
    assign tx_space    = (tx_free >= CW'(THRESH));
    assign rx_avail    = rx_stat.avail;
    assign rx_complete = rx_stat.complete;
    assign rx_overflow = rx_stat.overflow;

    // R6
    tx_both_full_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_push && tx_valid && tx_free == '0) |=> (tx_free == '0));

    // R7
    rx_flush_chk: assert property (@(posedge clk) disable iff (rst)
        rx_start |=> (rx_count == '0));

    // R3
    tx_valid_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> (tx_free != CW'(DEPTH)));

endmodule

// File: tb/pkt_buf_ctrl_test.sv
module pkt_buf_ctrl_test;
    logic clk = 1'b0, rst = 1'b1;
    logic host_wr = 0, host_rd = 0, tx_req = 0;
    logic rx_start = 0, rx_valid = 0, rx_ack = 0;
    logic [1:0] host_addr = 0;
    logic [7:0] host_wdata = 0, rx_len = 0, rx_byte = 0;
    logic [7:0] host_rdata, tx_data;
    logic tx_valid, tx_active, tx_underrun, tx_space;
    logic rx_avail, rx_complete, rx_overflow;
    logic [4:0] tx_free, rx_count;

    int n_run = 0, n_fail = 0, tx_seen = 0;
    logic [7:0] txq[$], rxq[$];

    always #10 clk = ~clk;

    pkt_buf_ctrl uut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // scoreboard monitor on the serializer side
    always @(negedge clk) begin
        if (!rst && tx_valid) begin
            tx_seen++;
            if (txq.size() == 0) check(0, "R3 unexpected tx byte", int'(tx_data), -1);
            else begin
                logic [7:0] e;
                e = txq.pop_front();
                check(tx_data == e, "R3 tx byte order", int'(tx_data), int'(e));
            end
        end
    end

    task automatic hwr(input logic [1:0] a, input logic [7:0] d);
        host_addr = a; host_wdata = d; host_wr = 1;
        @(posedge clk); #1 host_wr = 0;
    endtask

    task automatic push_tx(input logic [7:0] d, input bit kept);
        if (kept) txq.push_back(d);
        hwr(2'd0, d);
    endtask

    task automatic pull(input int n);
        tx_req = 1;
        repeat (n) @(posedge clk);
        #1 tx_req = 0;
    endtask

    task automatic rx_begin(input logic [7:0] len);
        rx_start = 1; rx_len = len;
        @(posedge clk); #1 rx_start = 0;
        rxq.delete();
    endtask

    task automatic rx_send(input logic [7:0] b, input bit ack, input bit rd, input bit kept);
        rx_valid = 1; rx_byte = b; rx_ack = ack; host_rd = rd;
        @(negedge clk);
        if (rd) begin
            logic [7:0] e;
            e = rxq.pop_front();
            check(host_rdata == e, "R6 rx read during write", int'(host_rdata), int'(e));
        end
        if (kept) rxq.push_back(b);
        @(posedge clk); #1 rx_valid = 0; rx_ack = 0; host_rd = 0;
    endtask

    task automatic host_read();
        logic [7:0] e;
        host_rd = 1;
        @(negedge clk);
        e = rxq.pop_front();
        check(host_rdata == e, "R7 rx byte order", int'(host_rdata), int'(e));
        @(posedge clk); #1 host_rd = 0;
    endtask

    initial begin
        #(20 * 150000);
        check(0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R1
        check(tx_free == 16, "R1 tx_free", tx_free, 16);
        check(rx_count == 0, "R1 rx_count", rx_count, 0);
        check(tx_space == 1, "R1 tx_space", tx_space, 1);
        check({tx_active, tx_underrun, rx_avail, rx_complete, rx_overflow} == 0,
              "R1 flags", {tx_active, tx_underrun, rx_avail, rx_complete, rx_overflow}, 0);
        @(posedge clk); #1;

        // R3 short packet
        for (int i = 0; i < 5; i++) push_tx(8'h10 + 8'(i), 1);
        hwr(2'd1, 8'd5);
        hwr(2'd2, 8'd0);
        check(tx_active == 1, "R3 active after start", tx_active, 1);
        tx_seen = 0;
        tx_req = 1;
        while (tx_active) begin @(posedge clk); #1; end
        tx_req = 0;
        check(tx_seen == 5, "R3 bytes delivered", tx_seen, 5);
        check(tx_free == 16, "R3 fifo drained", tx_free, 16);

        // R2 drop when full, R4 threshold
        for (int i = 0; i < 17; i++) push_tx(8'h40 + 8'(i), i < 16);
        check(tx_free == 0, "R2 full write dropped", tx_free, 0);
        check(tx_space == 0, "R4 space low when full", tx_space, 0);
        hwr(2'd1, 8'd16);
        hwr(2'd2, 8'd0);
        pull(7);
        check(tx_free == 7 && tx_space == 0, "R4 seven free", tx_space, 0);
        pull(1);
        check(tx_free == 8 && tx_space == 1, "R4 eight free", tx_space, 1);
        tx_seen = 0;
        pull(8);
        check(tx_seen == 8 && tx_active == 0, "R2 drop not sent", tx_seen, 8);

        // R6 40-byte packet through full fifo, R3 saturation
        for (int i = 0; i < 16; i++) push_tx(8'h80 + 8'(i), 1);
        hwr(2'd1, 8'd50);
        hwr(2'd2, 8'd0);
        tx_seen = 0;
        for (int k = 0; k < 24; k++) begin
            tx_req = 1; host_addr = 0; host_wdata = 8'hA0 + 8'(k); host_wr = 1;
            txq.push_back(host_wdata);
            @(posedge clk); #1;
        end
        host_wr = 0;
        check(tx_free == 0, "R6 tx level held at full", tx_free, 0);
        while (tx_active) begin @(posedge clk); #1; end
        tx_req = 0;
        check(tx_seen == 40, "R3 length saturates at 40", tx_seen, 40);
        check(txq.size() == 0, "R3 queue empty", txq.size(), 0);

        // R5 underrun
        push_tx(8'h01, 1); push_tx(8'h02, 1);
        hwr(2'd1, 8'd4);
        hwr(2'd2, 8'd0);
        tx_seen = 0;
        pull(3);
        check(tx_underrun == 1 && tx_seen == 2, "R5 underrun set", tx_underrun, 1);
        check(tx_active == 1, "R5 length not consumed", tx_active, 1);
        push_tx(8'h03, 1); push_tx(8'h04, 1);
        pull(2);
        check(tx_active == 0 && tx_seen == 4, "R5 packet finishes", tx_seen, 4);
        check(tx_underrun == 1, "R5 underrun sticky", tx_underrun, 1);
        hwr(2'd1, 8'd0);
        hwr(2'd2, 8'd0);
        check(tx_underrun == 0 && tx_active == 0, "R5 cleared by start", tx_underrun, 0);

        // R7 R8 receive
        rx_begin(8'd10);
        check(rx_count == 0 && rx_complete == 0, "R7 start state", rx_count, 0);
        for (int i = 0; i < 7; i++) rx_send(8'h20 + 8'(i), 0, 0, 1);
        check(rx_avail == 0, "R8 seven held", rx_avail, 0);
        rx_send(8'h27, 0, 0, 1);
        check(rx_avail == 1 && rx_count == 8, "R8 eight held", rx_avail, 1);
        rx_send(8'h28, 0, 0, 1); rx_send(8'h29, 0, 0, 1);
        check(rx_complete == 1, "R7 complete", rx_complete, 1);
        rx_send(8'h2A, 0, 0, 0);
        check(rx_count == 10, "R7 byte past length ignored", rx_count, 10);
        for (int i = 0; i < 10; i++) host_read();
        check(rx_avail == 0, "R8 empty", rx_avail, 0);

        rx_begin(8'd3);
        for (int i = 0; i < 3; i++) rx_send(8'h30 + 8'(i), 0, 0, 1);
        check(rx_avail == 1 && rx_count == 3, "R8 complete short", rx_avail, 1);
        for (int i = 0; i < 3; i++) host_read();

        // R9 overflow and R6 simultaneous
        rx_begin(8'd20);
        for (int i = 0; i < 16; i++) rx_send(8'h50 + 8'(i), 0, 0, 1);
        check(rx_count == 16 && rx_overflow == 0, "R9 full no overflow", rx_count, 16);
        rx_send(8'h60, 0, 1, 1);
        check(rx_count == 16 && rx_overflow == 0, "R6 rx write with read", rx_overflow, 0);
        rx_send(8'h61, 0, 0, 0);
        check(rx_overflow == 1 && rx_count == 16, "R9 overflow set", rx_overflow, 1);
        for (int i = 0; i < 13; i++) host_read();
        check(rx_overflow == 1, "R9 overflow sticky", rx_overflow, 1);
        rx_begin(8'd2);
        check(rx_overflow == 0 && rx_count == 0, "R7 start flushes", rx_count, 0);

        // R10 acknowledge bytes
        rx_send(8'hEE, 1, 0, 0);
        check(rx_count == 0, "R10 ack not stored", rx_count, 0);
        rx_send(8'h71, 0, 0, 1); rx_send(8'h72, 0, 0, 1);
        check(rx_count == 2 && rx_complete == 1, "R10 ack kept length", rx_complete, 1);
        host_read(); host_read();

        repeat (2) @(posedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule